// File: doc/BRIEF.md
# Two-Level Interrupt Status and Mask

This block gathers eleven event sources of a storage host controller into one interrupt line. Each source delivers single-cycle pulses, and every pulse sets a sticky bit in the event status register. A bit stays set until software clears it. Clearing works by writing zero: a write to the status register clears every bit that is zero in the write data and leaves alone every bit that is one. Writing all zeros therefore acknowledges every pending event at once.

Two levels of gating sit between the status bits and the interrupt pin. The first is a per-source mask with set-to-block polarity: a one blocks that source. The mask comes out of reset with every source blocked. Its bits are assigned as follows: bit 0 is the command source, bit 1 critical error, bit 2 error and bit 3 link error. The second level is a single controller-wide enable, taken from bit 11 of the data written to the enable register. The interrupt output is registered and level-sensitive. It is high while the enable is on and at least one status bit is set whose mask bit is clear.

Software drives separate write strobes for the three registers from a shared data bus. The current register contents are presented on output ports.

Top module: `evt_irq_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it falls, status reads 0x000, mask reads 0x7FF, the enable reads 0 and the interrupt output is 0.
- R2: A pulse on event input i sets status bit i on the next clock edge, and the bit stays set after the pulse ends until software clears it. Status bit 0 is the command event and status bit 3 is the link-error event.
- R3: A status write clears each bit whose write-data bit is 0 and leaves each bit whose write-data bit is 1 unchanged. A write of all zeros clears every pending bit.
- R4: When an event pulse and a status write that clears the same bit fall in the same cycle, the bit ends up set.
- R5: A mask write loads write-data bits 10:0 into the mask. A mask bit of 1 keeps the matching status bit from raising the interrupt.
- R6: An enable write loads write-data bit 11 into the enable. The other write-data bits have no effect on the enable.
- R7: The interrupt output is registered. In each cycle it equals the enable AND the OR over all bits of (status AND NOT mask), using the register values of the cycle before.
- R8: While the enable is 0, the interrupt output stays low whatever the status and mask contents.
- R9: The interrupt output is a level. It stays high until the contributing status bits are cleared or masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 11 | Event pulses, one per source |
| wr_stat | input | 1 | Write strobe for the status register (clear where data is 0) |
| wr_mask | input | 1 | Write strobe for the mask register |
| wr_ena | input | 1 | Write strobe for the enable register |
| wr_data | input | 32 | Shared write data |
| stat_q | output | 11 | Current event status |
| mask_q | output | 11 | Current mask (1 blocks) |
| ena_q | output | 1 | Current controller-wide enable |
| irq | output | 1 | Registered level interrupt |

## Verification
Two functions can fall in the same cycle: an event pulse setting a status bit, and a software write that clears that same bit with a zero. The bench forces the overlap in a directed case. It first sets a bit, then pulses that bit while writing all zeros to status, and expects only that bit to remain set. Random traffic also produces the overlap often, because events and status writes are drawn independently. In those cycles the bench model's rule, new status = events OR (old status AND write data), judges the result.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int unsigned EVT_N   = 11;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ENA_POS = 11;
  localparam logic [EVT_N-1:0] ALL_BLOCKED = {EVT_N{1'b1}};

  localparam int unsigned SRC_CMD  = 0;
  localparam int unsigned SRC_CRIT = 1;
  localparam int unsigned SRC_ERR  = 2;
  localparam int unsigned SRC_LINK = 3;
endpackage

// File: rtl/evt_status_bank.sv
module evt_status_bank #(
  parameter int unsigned N = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_pulse,
  input  logic         wr_en,
  input  logic [N-1:0] keep_bits,
  output logic [N-1:0] stat
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic held;
    always_comb begin
      held = stat[i];
      if (wr_en) held = stat[i] & keep_bits[i];
    end
    // a set in the same cycle as a clear wins
    always_ff @(posedge clk) begin
      if (rst) stat[i] <= 1'b0;
      else     stat[i] <= set_pulse[i] | held;
    end
  end
endmodule

// File: rtl/evt_gate_regs.sv
module evt_gate_regs #(
  parameter int unsigned N      = 11,
  parameter int unsigned DW     = 32,
  parameter int unsigned EN_BIT = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_mask,
  input  logic          wr_ena,
  input  logic [DW-1:0] wdata,
  output logic [N-1:0]  mask,
  output logic          ena
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= {N{1'b1}};
      ena  <= 1'b0;
    end else begin
      if (wr_mask) mask <= wdata[N-1:0];
      if (wr_ena)  ena  <= wdata[EN_BIT];
    end
  end
endmodule

// File: rtl/evt_irq_out.sv
module evt_irq_out #(
  parameter int unsigned N = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] stat,
  input  logic [N-1:0] mask,
  input  logic         ena,
  output logic         irq
);
  logic [N-1:0] live;
  logic         any_live;

  assign live     = stat & ~mask;
  assign any_live = |live;

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= ena & any_live;
  end
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [EVT_N-1:0]  evt_pulse,
  input  logic              wr_stat,
  input  logic              wr_mask,
  input  logic              wr_ena,
  input  logic [DATA_W-1:0] wr_data,
  output logic [EVT_N-1:0]  stat_q,
  output logic [EVT_N-1:0]  mask_q,
  output logic              ena_q,
  output logic              irq
);
  evt_status_bank #(.N(EVT_N)) u_stat (
    .clk       (clk),
    .rst       (rst),
    .set_pulse (evt_pulse),
    .wr_en     (wr_stat),
    .keep_bits (wr_data[EVT_N-1:0]),
    .stat      (stat_q)
  );

  evt_gate_regs #(.N(EVT_N), .DW(DATA_W), .EN_BIT(ENA_POS)) u_gate (
    .clk     (clk),
    .rst     (rst),
    .wr_mask (wr_mask),
    .wr_ena  (wr_ena),
    .wdata   (wr_data),
    .mask    (mask_q),
    .ena     (ena_q)
  );

  evt_irq_out #(.N(EVT_N)) u_out (
    .clk  (clk),
    .rst  (rst),
    .stat (stat_q),
    .mask (mask_q),
    .ena  (ena_q),
    .irq  (irq)
  );
endmodule

// File: rtl/evt_irq_ctrl_chk.sv
module evt_irq_ctrl_chk
  import evt_irq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [EVT_N-1:0]  evt_pulse,
  input logic              wr_stat,
  input logic              wr_mask,
  input logic              wr_ena,
  input logic [DATA_W-1:0] wr_data,
  input logic [EVT_N-1:0]  stat_q,
  input logic [EVT_N-1:0]  mask_q,
  input logic              ena_q,
  input logic              irq
);
  AST_RESET_DEFAULTS: assert property (@(posedge clk)
    rst |=> (stat_q == '0 && mask_q == ALL_BLOCKED && !ena_q && !irq)); // R1

  AST_EVT_STICKS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & $past(evt_pulse)) == $past(evt_pulse))); // R4

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!wr_stat && evt_pulse == '0) |=> stat_q == $past(stat_q)); // R2

  AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && evt_pulse == '0) |=> stat_q == ($past(stat_q) & $past(wr_data[EVT_N-1:0]))); // R3

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
    wr_mask |=> mask_q == $past(wr_data[EVT_N-1:0])); // R5

  AST_ENA_LOAD: assert property (@(posedge clk) disable iff (rst)
    wr_ena |=> ena_q == $past(wr_data[ENA_POS])); // R6

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq == ($past(ena_q) && ($past(stat_q) & ~$past(mask_q)) != '0)); // R7

  AST_ENA_GATES: assert property (@(posedge clk) disable iff (rst)
    !ena_q |=> !irq); // R8
endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk u_chk (.*);

// File: tb/sim_evt_irq_ctrl.sv
`timescale 1ns/1ps
module sim_evt_irq_ctrl;
  localparam int N  = 11;
  localparam int DW = 32;
  localparam int EB = 11;

  logic          clk = 1'b0;
  logic          rst;
  logic [N-1:0]  evt_pulse;
  logic          wr_stat, wr_mask, wr_ena;
  logic [DW-1:0] wr_data;
  logic [N-1:0]  stat_q, mask_q;
  logic          ena_q, irq;

  always #4 clk = ~clk;

  evt_irq_ctrl u0 (
    .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .wr_stat(wr_stat),
    .wr_mask(wr_mask), .wr_ena(wr_ena), .wr_data(wr_data),
    .stat_q(stat_q), .mask_q(mask_q), .ena_q(ena_q), .irq(irq)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [N-1:0] m_stat, m_mask;
  logic         m_ena, m_irq;

  function automatic logic [N-1:0] f_stat(input logic [N-1:0] s, input logic [N-1:0] e,
                                          input logic w, input logic [N-1:0] d);
    return e | (w ? (s & d) : s);
  endfunction

  function automatic logic f_irq(input logic en, input logic [N-1:0] s, input logic [N-1:0] m);
    return en && ((s & ~m) != '0);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    check("R2 R3 status", 32'(stat_q), 32'(m_stat));
    check("R5 mask", 32'(mask_q), 32'(m_mask));
    check("R6 enable", 32'(ena_q), 32'(m_ena));
    check("R7 irq", 32'(irq), 32'(m_irq));
  endtask

  task automatic cyc(input logic [N-1:0] e, input logic ws, input logic wm,
                     input logic we, input logic [DW-1:0] d);
    evt_pulse = e; wr_stat = ws; wr_mask = wm; wr_ena = we; wr_data = d;
    @(posedge clk);
    m_irq  = f_irq(m_ena, m_stat, m_mask);
    m_stat = f_stat(m_stat, e, ws, d[N-1:0]);
    if (wm) m_mask = d[N-1:0];
    if (we) m_ena = d[EB];
    @(negedge clk);
    evt_pulse = '0; wr_stat = 0; wr_mask = 0; wr_ena = 0; wr_data = '0;
    check_all();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd2718));
    rst = 1; evt_pulse = '0; wr_stat = 0; wr_mask = 0; wr_ena = 0; wr_data = '0;
    m_stat = '0; m_mask = '1; m_ena = 0; m_irq = 0;
    repeat (3) @(negedge clk);
    // R1: values during reset
    check("R1 status", 32'(stat_q), 32'h0);
    check("R1 mask", 32'(mask_q), 32'h7FF);
    check("R1 enable", 32'(ena_q), 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    rst = 0;
    @(negedge clk);
    check_all();

    // R2: command event (bit 0) and link error event (bit 3) stick
    cyc(11'h009, 0, 0, 0, '0);
    cyc('0, 0, 0, 0, '0);
    check("R2 sticky", 32'(stat_q), 32'h009);

    // R3: a one in the write data keeps the bit, a zero clears it
    cyc('0, 1, 0, 0, 32'h008);
    check("R3 partial clear", 32'(stat_q), 32'h008);

    // R4: set wins over a same-cycle all-zero clear
    cyc(11'h020, 0, 0, 0, '0);
    cyc(11'h020, 1, 0, 0, 32'h0);
    check("R4 set wins", 32'(stat_q), 32'h020);

    // R6: only bit 11 drives the enable
    cyc('0, 0, 0, 1, 32'hFFFF_F7FF);
    check("R6 other bits ignored", 32'(ena_q), 32'h0);

    // R8: unmasked pending bit but enable off keeps irq low
    cyc('0, 0, 1, 0, 32'h0);
    cyc('0, 0, 0, 0, '0);
    check("R8 enable off", 32'(irq), 32'h0);

    // R7 / R9: enable on, irq follows one cycle later and holds
    cyc('0, 0, 0, 1, 32'h800);
    check("R7 irq not yet", 32'(irq), 32'h0);
    cyc('0, 0, 0, 0, '0);
    check("R7 irq asserted", 32'(irq), 32'h1);
    cyc('0, 0, 0, 0, '0);
    check("R9 irq held", 32'(irq), 32'h1);
    // R5: masking the source drops irq
    cyc('0, 0, 1, 0, 32'h020);
    cyc('0, 0, 0, 0, '0);
    check("R5 masked", 32'(irq), 32'h0);
    // R3: all-zero write clears everything
    cyc('0, 1, 1, 0, 32'h0);
    check("R3 clear all", 32'(stat_q), 32'h0);

    for (int k = 0; k < 4000; k++) begin
      logic [N-1:0]  e;
      logic [DW-1:0] d;
      e = '0;
      for (int b = 0; b < N; b++) e[b] = ($urandom % 12) == 0;
      d = $urandom;
      cyc(e, ($urandom % 5) == 0, ($urandom % 9) == 0, ($urandom % 9) == 0, d);
    end

    done = 1;
    finish_run();
  end
endmodule